// File: doc/BRIEF.md
# I/O Interrupt Redirection Table

This block turns external interrupt pins into interrupt messages. It holds one 64-bit redirection entry per pin. Software programs the entries through a two-register window: an index register picks a 32-bit word and a data port reads or writes that word. Each entry sets the pin's polarity and its trigger style (edge or level). It also sets a mask and the message contents: vector, delivery mode, destination and destination mode.

Every pin is compared against its programmed active level. An accepted request marks the entry as waiting for delivery. The block then offers one message at a time on a valid/ready output, lowest-numbered entry first. While `msg_valid` is high and `msg_ready` is low, the message stays asserted and all of its fields stay unchanged; the consumer may stall for any number of cycles. The message leaves on the first rising clock edge where both are high. The next message can appear one cycle after that. A level-triggered entry also sets a receipt flag when it fires and stays quiet until an end-of-interrupt notice with its vector clears that flag. The delivery modes for system management, non-maskable, init and external-controller interrupts always act on edges, whatever their trigger bit says.

Top module: `ioapic_redir_unit`

## Requirements
- R1: Index 0x01 reads (entries-1)<<16, which is 0x0017_0000 for 24 entries. Indexes 0x00, 0x02–0x0F and 0x40 upward read 0 and writes to them change nothing.
- R2: Entry k's low word is at index 0x10+2k and its high word at 0x11+2k. After reset every low word reads 0x0001_0000 (masked) and every high word reads 0.
- R3: Low-word layout is vector [7:0], delivery mode [10:8], logical destination [11], delivery status [12], polarity [13], receipt flag [14], trigger [15], mask [16]. The high word holds the destination in [31:24]. Only bits 0x0001_AFFF of the low word and 0xFF00_0000 of the high word take writes; all other bits read back unchanged by writes.
- R4: For an unmasked edge entry, a rising transition of the polarity-adjusted pin sets delivery status one cycle later. The message appears on the output the cycle after that, carrying the entry's vector, mode, destination and destination-mode bit.
- R5: Polarity 1 makes the pin active low: a falling pin edge fires the entry and a rising one does not.
- R6: For an unmasked level entry (trigger 1, mode fixed or lowest-priority), an active pin sets the receipt flag and delivery status together. No further message is sent while the receipt flag is set.
- R7: An end-of-interrupt whose vector equals an entry's vector clears that entry's receipt flag. A non-matching vector leaves it set. If the pin is still active, a new request follows on the next cycle.
- R8: Delivery modes 010, 100, 101 and 111 act on edges even with trigger set to 1. The receipt flag stays 0 and a held pin gives one message.
- R9: A mask of 1 stops new requests: pin edges seen while masked are lost. A request already waiting is kept, reported in delivery status, and sent once the mask is cleared. A level pin still active at unmask fires.
- R10: When several unmasked entries are waiting, the lowest-numbered one is sent first.
- R11: While msg_valid is high without msg_ready, valid and all message fields hold. A handshake drops valid and clears that entry's delivery status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr_en | input | 1 | Load the index register |
| idx_wr_data | input | 8 | New index value |
| win_wr_en | input | 1 | Write the word selected by the index |
| win_wr_data | input | 32 | Data port write value |
| win_rd_data | output | 32 | Data port read value for the current index |
| irq_pins | input | 24 | Interrupt input pins, one per entry |
| eoi_valid | input | 1 | End-of-interrupt notice strobe |
| eoi_vector | input | 8 | Vector carried by the notice |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_dest | output | 8 | Message destination |
| msg_dest_logical | output | 1 | Destination mode, 1 = logical |

## Verification
The hardest state to reach from the ports is an entry that holds a latched request while it is masked. A request normally leaves two cycles after its pin edge, so software has no chance to mask it first. The bench first fires one entry and leaves its message unaccepted, which keeps the output busy. It then fires a second entry and masks it while the first message is still stalled. After the stalled message is accepted, the bench confirms that the masked entry reports delivery status but sends nothing, and that clearing the mask releases its message. The same stall is used to queue three entries at once for the priority check.

// File: rtl/ioapic_pkg.sv
package ioapic_pkg;

  localparam int VEC_W  = 8;
  localparam int MODE_W = 3;
  localparam int DEST_W = 8;
  localparam int WORD_W = 32;

  typedef enum logic [MODE_W-1:0] {
    DM_FIXED  = 3'b000,
    DM_LOWPRI = 3'b001,
    DM_SMI    = 3'b010,
    DM_RSV3   = 3'b011,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_RSV6   = 3'b110,
    DM_EXTINT = 3'b111
  } dmode_e;

  // software-programmable part of one entry
  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              trig;
    logic              pol;
    logic              dlog;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vec;
  } rte_t;

  localparam rte_t RTE_RST = '{dest: '0, mask: 1'b1, trig: 1'b0, pol: 1'b0,
                               dlog: 1'b0, mode: '0, vec: '0};

  // modes that always behave as edge-sensitive
  function automatic logic forced_edge(input logic [MODE_W-1:0] m);
    return (m == DM_SMI) || (m == DM_NMI) || (m == DM_INIT) || (m == DM_EXTINT);
  endfunction

endpackage

// File: rtl/ioapic_cfg_regs.sv
module ioapic_cfg_regs
  import ioapic_pkg::*;
#(
  parameter int N     = 24,
  parameter int IDX_W = 8,
  parameter int BASE  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_we,
  input  logic [IDX_W-1:0]  idx_wdata,
  input  logic              data_we,
  input  logic [WORD_W-1:0] data_wdata,
  output logic [WORD_W-1:0] data_rdata,
  output logic [IDX_W-1:0]  cur_idx,
  input  logic [N-1:0]      irr,
  input  logic [N-1:0]      dstat,
  output rte_t              ent [N]
);

  localparam int TOP = BASE + 2 * N;
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(N - 1) << 16;

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] off;
  logic             in_tbl;
  logic             hi_half;
  rte_t             tbl_q [N];

  assign in_tbl  = (int'(idx_q) >= BASE) && (int'(idx_q) < TOP);
  assign off     = idx_q - IDX_W'(BASE);
  assign hi_half = off[0];
  assign cur_idx = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= '0;
    else if (idx_we) idx_q <= idx_wdata;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) begin
        tbl_q[i] <= RTE_RST;
      end else if (data_we && in_tbl && (int'(off[IDX_W-1:1]) == i)) begin
        if (hi_half) begin
          tbl_q[i].dest <= data_wdata[31:24];
        end else begin
          tbl_q[i].vec  <= data_wdata[7:0];
          tbl_q[i].mode <= data_wdata[10:8];
          tbl_q[i].dlog <= data_wdata[11];
          tbl_q[i].pol  <= data_wdata[13];
          tbl_q[i].trig <= data_wdata[15];
          tbl_q[i].mask <= data_wdata[16];
        end
      end
    end
  end

  always_comb begin
    data_rdata = '0;
    if (idx_q == IDX_W'(1)) begin
      data_rdata = LAST_WORD;
    end else if (in_tbl) begin
      for (int i = 0; i < N; i++) begin
        if (int'(off[IDX_W-1:1]) == i) begin
          if (hi_half)
            data_rdata = {tbl_q[i].dest, 24'h0};
          else
            data_rdata = {15'h0, tbl_q[i].mask, tbl_q[i].trig, irr[i], tbl_q[i].pol,
                          dstat[i], tbl_q[i].dlog, tbl_q[i].mode, tbl_q[i].vec};
        end
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign ent[g] = tbl_q[g];
  end

endmodule

// File: rtl/ioapic_src_detect.sv
module ioapic_src_detect
  import ioapic_pkg::*;
#(
  parameter int N = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     pins,
  input  rte_t             ent [N],
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  input  logic [N-1:0]     clr,
  output logic [N-1:0]     pending,
  output logic [N-1:0]     irr
);

  for (genvar g = 0; g < N; g++) begin : g_src
    logic act, prev_q, pend_q, irr_q;
    logic lvl, edge_hit, lvl_hit, eoi_hit;

    assign act      = pins[g] ^ ent[g].pol;
    assign lvl      = ent[g].trig & ~forced_edge(ent[g].mode);
    assign edge_hit = ~lvl & act & ~prev_q & ~ent[g].mask;
    assign lvl_hit  = lvl & act & ~irr_q & ~pend_q & ~ent[g].mask;
    assign eoi_hit  = eoi_valid && (eoi_vector == ent[g].vec);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        pend_q <= 1'b0;
        irr_q  <= 1'b0;
      end else begin
        prev_q <= act;
        pend_q <= (pend_q & ~clr[g]) | edge_hit | lvl_hit;
        if (lvl_hit)      irr_q <= 1'b1;
        else if (eoi_hit) irr_q <= 1'b0;
      end
    end

    assign pending[g] = pend_q;
    assign irr[g]     = irr_q;
  end

endmodule

// File: rtl/ioapic_msg_sel.sv
module ioapic_msg_sel
  import ioapic_pkg::*;
#(
  parameter int N = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      pending,
  input  rte_t              ent [N],
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [VEC_W-1:0]  msg_vector,
  output logic [MODE_W-1:0] msg_mode,
  output logic [DEST_W-1:0] msg_dest,
  output logic              msg_dest_logical,
  output logic [N-1:0]      clr
);

  localparam int SEL_W = (N > 1) ? $clog2(N) : 1;

  logic             found;
  logic [SEL_W-1:0] pick;
  rte_t             pick_ent;
  logic             valid_q;
  logic [SEL_W-1:0] sel_q;
  rte_t             hold_q;

  // fixed priority: lowest index wins
  always_comb begin
    found    = 1'b0;
    pick     = '0;
    pick_ent = RTE_RST;
    for (int i = N - 1; i >= 0; i--) begin
      if (pending[i] && !ent[i].mask) begin
        found    = 1'b1;
        pick     = SEL_W'(i);
        pick_ent = ent[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      sel_q   <= '0;
      hold_q  <= RTE_RST;
    end else if (valid_q) begin
      if (msg_ready) valid_q <= 1'b0;
    end else if (found) begin
      valid_q <= 1'b1;
      sel_q   <= pick;
      hold_q  <= pick_ent;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_clr
    assign clr[g] = valid_q && msg_ready && (sel_q == SEL_W'(g));
  end

  assign msg_valid        = valid_q;
  assign msg_vector       = hold_q.vec;
  assign msg_mode         = hold_q.mode;
  assign msg_dest         = hold_q.dest;
  assign msg_dest_logical = hold_q.dlog;

endmodule

// File: rtl/ioapic_redir_unit.sv
module ioapic_redir_unit
  import ioapic_pkg::*;
#(
  parameter int N        = 24,
  parameter int IDX_W    = 8,
  parameter int TBL_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr_en,
  input  logic [IDX_W-1:0]  idx_wr_data,
  input  logic              win_wr_en,
  input  logic [WORD_W-1:0] win_wr_data,
  output logic [WORD_W-1:0] win_rd_data,
  input  logic [N-1:0]      irq_pins,
  input  logic              eoi_valid,
  input  logic [VEC_W-1:0]  eoi_vector,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [VEC_W-1:0]  msg_vector,
  output logic [MODE_W-1:0] msg_mode,
  output logic [DEST_W-1:0] msg_dest,
  output logic              msg_dest_logical
);

  rte_t             ent [N];
  logic [N-1:0]     pending;
  logic [N-1:0]     irr;
  logic [N-1:0]     clr;
  logic [IDX_W-1:0] cur_idx;

  ioapic_cfg_regs #(.N(N), .IDX_W(IDX_W), .BASE(TBL_BASE)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_we     (idx_wr_en),
    .idx_wdata  (idx_wr_data),
    .data_we    (win_wr_en),
    .data_wdata (win_wr_data),
    .data_rdata (win_rd_data),
    .cur_idx    (cur_idx),
    .irr        (irr),
    .dstat      (pending),
    .ent        (ent)
  );

  ioapic_src_detect #(.N(N)) u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .pins       (irq_pins),
    .ent        (ent),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .clr        (clr),
    .pending    (pending),
    .irr        (irr)
  );

  ioapic_msg_sel #(.N(N)) u_sel (
    .clk              (clk),
    .rst_n            (rst_n),
    .pending          (pending),
    .ent              (ent),
    .msg_valid        (msg_valid),
    .msg_ready        (msg_ready),
    .msg_vector       (msg_vector),
    .msg_mode         (msg_mode),
    .msg_dest         (msg_dest),
    .msg_dest_logical (msg_dest_logical),
    .clr              (clr)
  );

endmodule

// File: rtl/ioapic_redir_chk.sv
module ioapic_redir_chk #(
  parameter int N     = 24,
  parameter int IDX_W = 8,
  parameter int BASE  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] idx,
  input logic [31:0]      rd,
  input logic             valid,
  input logic             ready,
  input logic [7:0]       vec,
  input logic [2:0]       mode,
  input logic [7:0]       dest,
  input logic             dlog
);

  localparam logic [31:0] LAST_WORD = 32'(N - 1) << 16;
  logic in_tbl;
  assign in_tbl = (int'(idx) >= BASE) && (int'(idx) < BASE + 2 * N);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable({vec, mode, dest, dlog}));

  a_r11_drop_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid) |-> $past(ready));

  a_r1_last_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == IDX_W'(1)) |-> (rd == LAST_WORD));

  a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != IDX_W'(1) && !in_tbl) |-> (rd == 32'h0));

  a_r3_low_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tbl && (idx[0] == BASE[0])) |-> (rd[31:17] == '0));

  a_r3_high_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tbl && (idx[0] != BASE[0])) |-> (rd[23:0] == '0));

endmodule

bind ioapic_redir_unit ioapic_redir_chk #(.N(N), .IDX_W(IDX_W), .BASE(TBL_BASE)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .idx   (cur_idx),
  .rd    (win_rd_data),
  .valid (msg_valid),
  .ready (msg_ready),
  .vec   (msg_vector),
  .mode  (msg_mode),
  .dest  (msg_dest),
  .dlog  (msg_dest_logical)
);

// File: tb/tb_ioapic_redir_unit.sv
module tb_ioapic_redir_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_wr_en = 1'b0;
  logic [7:0]  idx_wr_data = '0;
  logic        win_wr_en = 1'b0;
  logic [31:0] win_wr_data = '0;
  logic [31:0] win_rd_data;
  logic [23:0] irq_pins = '0;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;
  logic        msg_valid;
  logic        msg_ready = 1'b0;
  logic [7:0]  msg_vector;
  logic [2:0]  msg_mode;
  logic [7:0]  msg_dest;
  logic        msg_dest_logical;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] sh_lo [24];
  logic [31:0] sh_hi [24];

  always #2 clk = ~clk;

  ioapic_redir_unit dut (
    .clk(clk), .rst_n(rst_n),
    .idx_wr_en(idx_wr_en), .idx_wr_data(idx_wr_data),
    .win_wr_en(win_wr_en), .win_wr_data(win_wr_data), .win_rd_data(win_rd_data),
    .irq_pins(irq_pins), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_mode(msg_mode), .msg_dest(msg_dest), .msg_dest_logical(msg_dest_logical)
  );

  function automatic logic [31:0] lo(input logic [7:0] v, input logic [2:0] m,
                                     input logic dl, input logic pol,
                                     input logic trig, input logic mask);
    return {15'h0, mask, trig, 1'b0, pol, 1'b0, dl, m, v};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] i);
    idx_wr_en = 1'b1; idx_wr_data = i;
    @(negedge clk);
    idx_wr_en = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);
    win_wr_en = 1'b1; win_wr_data = d;
    @(negedge clk);
    win_wr_en = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [31:0] d);
    set_idx(i);
    wr(d);
  endtask

  task automatic handshake();
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2417));
    @(negedge clk);
    do_reset();

    // R1 / R2 reset state and fixed words
    chk("R2 reset valid", 32'(msg_valid), 32'h0);
    set_idx(8'h01); chk("R1 last entry", win_rd_data, 32'h0017_0000);
    set_idx(8'h00); chk("R1 idx 00", win_rd_data, 32'h0);
    set_idx(8'h0F); chk("R1 idx 0F", win_rd_data, 32'h0);
    set_idx(8'h40); chk("R1 idx 40", win_rd_data, 32'h0);
    set_idx(8'hFF); chk("R1 idx FF", win_rd_data, 32'h0);
    set_idx(8'h10); chk("R2 entry0 low", win_rd_data, 32'h0001_0000);
    set_idx(8'h11); chk("R2 entry0 high", win_rd_data, 32'h0);
    set_idx(8'h3E); chk("R2 entry23 low", win_rd_data, 32'h0001_0000);
    set_idx(8'h3F); chk("R2 entry23 high", win_rd_data, 32'h0);
    for (int k = 0; k < 24; k++) begin
      sh_lo[k] = 32'h0001_0000;
      sh_hi[k] = 32'h0;
    end

    // R3 / R1 random register traffic; mask kept set so no pin fires
    for (int n = 0; n < 300; n++) begin
      int op;
      int k;
      logic [31:0] d;
      op = int'($urandom % 4);
      k  = int'($urandom % 24);
      d  = $urandom;
      if (op == 0) begin
        d = d | 32'h0001_0000;
        wr_reg(8'(8'h10 + 2 * k), d);
        sh_lo[k] = d & 32'h0001_AFFF;
        chk("R3 low write mask", win_rd_data, sh_lo[k]);
      end else if (op == 1) begin
        wr_reg(8'(8'h11 + 2 * k), d);
        sh_hi[k] = d & 32'hFF00_0000;
        chk("R3 high write mask", win_rd_data, sh_hi[k]);
      end else if (op == 2) begin
        logic [7:0] bad;
        bad = ($urandom % 2 == 0) ? 8'($urandom % 16) : 8'(8'h40 + $urandom % 8'hC0);
        if (bad == 8'h01) bad = 8'h00;
        wr_reg(bad, d);
        chk("R1 unmapped read", win_rd_data, 32'h0);
        set_idx(8'h01); chk("R1 last after write", win_rd_data, 32'h0017_0000);
      end else begin
        set_idx(8'(8'h10 + 2 * k)); chk("R2 low readback", win_rd_data, sh_lo[k]);
        set_idx(8'(8'h11 + 2 * k)); chk("R2 high readback", win_rd_data, sh_hi[k]);
      end
    end
    chk("R3 no message while masked", 32'(msg_valid), 32'h0);

    do_reset();

    // R4 edge entry 3
    wr_reg(8'h17, 32'h5A00_0000);
    wr_reg(8'h16, lo(8'h41, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0));
    irq_pins[3] = 1'b1;
    cyc(1);
    chk("R4 status set", 32'(win_rd_data[12]), 32'h1);
    chk("R4 not yet valid", 32'(msg_valid), 32'h0);
    cyc(1);
    chk("R4 valid", 32'(msg_valid), 32'h1);
    chk("R4 vector", 32'(msg_vector), 32'h41);
    chk("R4 mode", 32'(msg_mode), 32'h0);
    chk("R4 dest", 32'(msg_dest), 32'h5A);
    chk("R4 dest logical", 32'(msg_dest_logical), 32'h1);
    cyc(3);
    chk("R11 held valid", 32'(msg_valid), 32'h1);
    chk("R11 held vector", 32'(msg_vector), 32'h41);
    handshake();
    chk("R11 valid drop", 32'(msg_valid), 32'h0);
    chk("R11 status clear", 32'(win_rd_data[12]), 32'h0);
    irq_pins[3] = 1'b0;
    cyc(2);
    chk("R4 falling no msg", 32'(msg_valid), 32'h0);

    // R5 active-low entry 5
    irq_pins[5] = 1'b1;
    wr_reg(8'h1B, 32'h3300_0000);
    wr_reg(8'h1A, lo(8'h55, 3'b001, 1'b0, 1'b1, 1'b0, 1'b0));
    cyc(3);
    chk("R5 high level quiet", 32'(msg_valid), 32'h0);
    irq_pins[5] = 1'b0;
    cyc(2);
    chk("R5 valid", 32'(msg_valid), 32'h1);
    chk("R5 vector", 32'(msg_vector), 32'h55);
    chk("R5 mode", 32'(msg_mode), 32'h1);
    chk("R5 dest", 32'(msg_dest), 32'h33);
    handshake();

    // R6 / R7 level entry 7
    wr_reg(8'h1E, lo(8'h70, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0));
    irq_pins[7] = 1'b1;
    cyc(1);
    chk("R6 receipt+status", win_rd_data & 32'h5000, 32'h5000);
    cyc(1);
    chk("R6 valid", 32'(msg_valid), 32'h1);
    chk("R6 vector", 32'(msg_vector), 32'h70);
    handshake();
    cyc(4);
    chk("R6 no repeat", 32'(msg_valid), 32'h0);
    chk("R6 receipt held", 32'(win_rd_data[14]), 32'h1);
    eoi(8'h71);
    cyc(2);
    chk("R7 mismatch no msg", 32'(msg_valid), 32'h0);
    chk("R7 mismatch keeps flag", 32'(win_rd_data[14]), 32'h1);
    eoi(8'h70);
    chk("R7 flag cleared", 32'(win_rd_data[14]), 32'h0);
    cyc(1);
    chk("R7 re-detect flag", 32'(win_rd_data[14]), 32'h1);
    cyc(1);
    chk("R7 re-sent", 32'(msg_valid), 32'h1);
    chk("R7 re-sent vector", 32'(msg_vector), 32'h70);
    handshake();
    irq_pins[7] = 1'b0;
    eoi(8'h70);
    cyc(3);
    chk("R7 idle after release", 32'(msg_valid), 32'h0);
    chk("R7 idle flag", 32'(win_rd_data[14]), 32'h0);

    // R8 NMI mode with trigger=1, entry 9
    wr_reg(8'h22, lo(8'h99, 3'b100, 1'b0, 1'b0, 1'b1, 1'b0));
    irq_pins[9] = 1'b1;
    cyc(2);
    chk("R8 valid", 32'(msg_valid), 32'h1);
    chk("R8 vector", 32'(msg_vector), 32'h99);
    chk("R8 mode", 32'(msg_mode), 32'h4);
    chk("R8 no receipt", 32'(win_rd_data[14]), 32'h0);
    handshake();
    cyc(4);
    chk("R8 single message", 32'(msg_valid), 32'h0);
    irq_pins[9] = 1'b0;
    cyc(1);

    // R9 latched edge survives masking (entry 11), output kept busy by entry 3
    wr_reg(8'h26, lo(8'hB0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0));
    irq_pins[3] = 1'b1;
    cyc(1);
    irq_pins[11] = 1'b1;
    cyc(2);
    wr(lo(8'hB0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1));
    chk("R9 busy vector", 32'(msg_vector), 32'h41);
    handshake();
    cyc(3);
    chk("R9 masked not sent", 32'(msg_valid), 32'h0);
    chk("R9 masked status", 32'(win_rd_data[12]), 32'h1);
    wr(lo(8'hB0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0));
    cyc(1);
    chk("R9 unmask sends", 32'(msg_valid), 32'h1);
    chk("R9 unmask vector", 32'(msg_vector), 32'hB0);
    handshake();
    irq_pins[3] = 1'b0;
    irq_pins[11] = 1'b0;
    cyc(1);

    // R9 edge while masked is lost
    wr(lo(8'hB0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1));
    irq_pins[11] = 1'b1;
    cyc(2);
    irq_pins[11] = 1'b0;
    cyc(1);
    wr(lo(8'hB0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0));
    cyc(3);
    chk("R9 masked edge dropped", 32'(msg_valid), 32'h0);
    chk("R9 masked edge status", 32'(win_rd_data[12]), 32'h0);

    // R9 level active at unmask (entry 13)
    wr_reg(8'h2A, lo(8'hD0, 3'b000, 1'b0, 1'b0, 1'b1, 1'b1));
    irq_pins[13] = 1'b1;
    cyc(3);
    chk("R9 masked level quiet", 32'(msg_valid), 32'h0);
    wr(lo(8'hD0, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0));
    cyc(2);
    chk("R9 level at unmask", 32'(msg_valid), 32'h1);
    chk("R9 level vector", 32'(msg_vector), 32'hD0);
    handshake();
    irq_pins[13] = 1'b0;
    eoi(8'hD0);

    // R10 priority among 3, 9, 11
    irq_pins[3] = 1'b1;
    cyc(1);
    irq_pins[11] = 1'b1;
    irq_pins[9] = 1'b1;
    cyc(3);
    chk("R10 first", 32'(msg_vector), 32'h41);
    handshake();
    cyc(1);
    chk("R10 second valid", 32'(msg_valid), 32'h1);
    chk("R10 second", 32'(msg_vector), 32'h99);
    handshake();
    cyc(1);
    chk("R10 third", 32'(msg_vector), 32'hB0);
    handshake();
    irq_pins = '0;
    cyc(3);
    chk("R10 drained", 32'(msg_valid), 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule